// File: doc/BRIEF.md
# Multi-write output queue with duplicate filter

This block is the output buffer of a single switch port placed after several parallel switching planes. A slot is one clock cycle. In each slot every plane may hand over one cell, so up to K cells can arrive at once. The block stores them in one circular buffer and sends at most one cell per slot toward the output link.

When the fabric sends the same cell down several planes, each copy carries the same tag (source port and sequence number). Only the copy on the lowest-numbered plane is kept. The block also reports a credit: the number of cells it can still take in the next slot. This credit caps the acknowledgments returned to probes when backpressure is on. Without backpressure, cells that find no room are dropped.

Top module: `mwq_oq`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0 and, with `bp_en` high, `credit` equals the smaller of DEPTH and K.
- R2: Distinct cells that arrive in one slot on several planes are all stored when there is room, and they leave in ascending plane order (plane 0 first).
- R3: Cells in one slot that share the same tag are stored once. The copy kept is the one from the lowest valid plane, with that plane's data.
- R4: While `out_valid` and `out_ready` are both high, exactly one cell leaves per cycle. Across slots, cells leave in the order they were stored.
- R5: The buffer never holds more than DEPTH cells. Free space is counted from the occupancy at the start of the slot. When the new unique cells exceed it, the lowest planes are stored first and the rest are lost, and the cells already stored are left unchanged.
- R6: With `bp_en` high, `credit` equals the smaller of (DEPTH minus the current occupancy) and K. If no more valid planes arrive than `credit`, no unique cell is lost.
- R7: With `bp_en` low, `credit` is always K, whatever the occupancy.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_tag` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| bp_en | input | 1 | 1 = credit limited by free space, 0 = credit fixed at K |
| in_valid | input | K | Per-plane cell present |
| in_tag | input | K*TW | Per-plane cell tag; plane i at bits [i*TW +: TW] |
| in_data | input | K*W | Per-plane cell word; plane i at bits [i*W +: W] |
| out_ready | input | 1 | Output link takes the head cell this cycle |
| out_valid | output | 1 | Head cell present |
| out_data | output | W | Head cell word |
| out_tag | output | TW | Head cell tag |
| credit | output | $clog2(K+1) | Cells that may be granted in the next slot |

## Verification
The bench pairs copies on non-adjacent planes (0 with 2, 1 with 3) and checks that the lowest copy's data is kept. A filter that compared only neighbours, or that kept the last copy, would store extra cells or the wrong data. It fills the buffer and then offers cells while one cell is leaving. A design that counted the departing cell as free space would accept a cell there. With one free entry left, it checks that only the lowest valid plane is taken. A design that wrote the wrong plane, or advanced the write pointer by the raw valid count, would put the cells out of order or in the wrong place. Mixed traffic with random stalls and occasional duplicates checks the order of cells across slots, the credit under both settings of `bp_en`, and that the head cell holds still during a stall.

// File: rtl/mwq_oq.sv
module mwq_oq #(
  parameter int K     = 4,
  parameter int W     = 16,
  parameter int TW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(K+1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bp_en,
  input  logic [K-1:0]  in_valid,
  input  logic [K*TW-1:0] in_tag,
  input  logic [K*W-1:0]  in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [TW-1:0] out_tag,
  output logic [CW-1:0] credit
);

  logic [TW+W-1:0] mem [DEPTH];
  logic [AW-1:0]   wr, rd;
  logic [AW:0]     count, free, nacc;
  logic [K-1:0]    uniq, acc;
  logic [AW-1:0]   pos [K];
  logic            pop;

  assign free      = (AW+1)'(DEPTH) - count;
  assign out_valid = (count != '0);
  assign {out_tag, out_data} = mem[rd];
  assign pop       = out_valid & out_ready;
  assign credit    = (bp_en && int'(free) < K) ? CW'(free) : CW'(K);

  always_comb begin
    logic [AW:0] rank;
    rank = '0;
    for (int i = 0; i < K; i++) begin
      uniq[i] = in_valid[i];
      for (int j = 0; j < i; j++)
        if (in_valid[j] && in_tag[j*TW +: TW] == in_tag[i*TW +: TW])
          uniq[i] = 1'b0;
      acc[i] = uniq[i] && (rank < free);
      pos[i] = rank[AW-1:0];
      if (acc[i]) rank = rank + 1'b1;
    end
    nacc = rank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      wr    <= '0;
      rd    <= '0;
    end else begin
      count <= count + nacc - (AW+1)'(pop);
      wr    <= wr + nacc[AW-1:0];
      rd    <= rd + AW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < K; i++)
      if (acc[i])
        mem[wr + pos[i]] <= {in_tag[i*TW +: TW], in_data[i*W +: W]};
  end

  logic dup_acc;
  always_comb begin
    dup_acc = 1'b0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < i; j++)
        if (acc[i] && acc[j] && in_tag[j*TW +: TW] == in_tag[i*TW +: TW])
          dup_acc = 1'b1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R3
  uniq_store_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_acc);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R6
  credit_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_en && $countones(in_valid) <= int'(credit)) |-> (int'(nacc) == $countones(uniq)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_tag)));

endmodule

// File: tb/tb_mwq_oq.sv
module tb_mwq_oq;
  localparam int K = 4, W = 16, TW = 8, DEPTH = 8;
  localparam int CW = $clog2(K+1);

  logic clk = 0, rst_n = 0, bp_en = 1, out_ready = 0;
  logic [K-1:0] in_valid = '0;
  logic [K*TW-1:0] in_tag = '0;
  logic [K*W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic [TW-1:0] out_tag;
  logic [CW-1:0] credit;

  always #5 clk = ~clk;

  mwq_oq #(.K(K), .W(W), .TW(TW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bp_en(bp_en), .in_valid(in_valid),
    .in_tag(in_tag), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag), .credit(credit));

  int checks = 0, fails = 0;
  logic [TW+W-1:0] q[$];

  task automatic chk(input string lbl, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  task automatic slot(input string lbl, input logic bp, input logic [K-1:0] v,
                      input logic [K*TW-1:0] t, input logic [K*W-1:0] d, input logic rdy);
    int sz, fr, n;
    logic u;
    chk({lbl, " valid"}, 32'(out_valid), 32'(q.size() != 0));
    if (q.size() != 0) chk({lbl, " head"}, 32'({out_tag, out_data}), 32'(q[0]));
    fr = DEPTH - q.size();
    chk(bp_en ? "R6 credit" : "R7 credit", 32'(credit),
        bp_en ? 32'((fr < K) ? fr : K) : 32'(K));
    bp_en = bp; in_valid = v; in_tag = t; in_data = d; out_ready = rdy;
    sz = q.size();
    if (rdy && sz > 0) void'(q.pop_front());
    n = 0;
    for (int i = 0; i < K; i++) begin
      u = v[i];
      for (int j = 0; j < i; j++)
        if (v[j] && t[j*TW +: TW] == t[i*TW +: TW]) u = 0;
      if (u && n < DEPTH - sz) begin
        q.push_back({t[i*TW +: TW], d[i*W +: W]});
        n++;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [K*TW-1:0] t;
    logic [K*W-1:0] d;
    logic [K-1:0] v;
    int seq = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(out_valid), 0);
    chk("R1 credit in reset", 32'(credit), 32'(K < DEPTH ? K : DEPTH));
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", 32'(out_valid), 0);

    // R2: four distinct cells in one slot, then drain
    slot("R2", 1, 4'b1111, {8'h13, 8'h12, 8'h11, 8'h10},
         {16'hD003, 16'hD002, 16'hD001, 16'hD000}, 0);
    repeat (5) slot("R2", 1, 4'b0000, '0, '0, 1);

    // R3: copies on planes 0/2 and 1/3, lowest copy kept
    slot("R3", 1, 4'b1111, {8'h21, 8'h20, 8'h21, 8'h20},
         {16'hBBB3, 16'hBBB2, 16'hAAA1, 16'hAAA0}, 0);
    repeat (3) slot("R3", 1, 4'b0000, '0, '0, 1);

    // R5: fill, overflow, pop-then-offer, single free entry
    slot("R5", 1, 4'b1111, {8'h33, 8'h32, 8'h31, 8'h30},
         {16'h3003, 16'h3002, 16'h3001, 16'h3000}, 0);
    slot("R5", 1, 4'b1111, {8'h37, 8'h36, 8'h35, 8'h34},
         {16'h3007, 16'h3006, 16'h3005, 16'h3004}, 0);
    slot("R5 full", 1, 4'b1111, {8'h3B, 8'h3A, 8'h39, 8'h38},
         {16'h300B, 16'h300A, 16'h3009, 16'h3008}, 0);
    slot("R5 pop", 1, 4'b1010, {8'h3F, 8'h3E, 8'h3D, 8'h3C},
         {16'h300F, 16'h300E, 16'h300D, 16'h300C}, 1);
    slot("R5 one", 1, 4'b1010, {8'h43, 8'h42, 8'h41, 8'h40},
         {16'h4003, 16'h4002, 16'h4001, 16'h4000}, 0);
    // R8: stall with a full buffer, R7: credit ignores occupancy
    slot("R8 stall", 0, 4'b0000, '0, '0, 0);
    slot("R8 stall", 0, 4'b0000, '0, '0, 0);
    slot("R7", 1, 4'b0000, '0, '0, 0);
    repeat (10) slot("R5 drain", 1, 4'b0000, '0, '0, 1);

    // R4: mixed traffic with stalls and duplicates
    for (int s = 0; s < 60; s++) begin
      v = 4'(s * 7 + 3);
      for (int i = 0; i < K; i++) begin
        t[i*TW +: TW] = 8'(seq + i);
        d[i*W +: W] = 16'((seq + i) * 37 + s);
      end
      if (s % 3 == 0) t[3*TW +: TW] = t[0 +: TW];
      seq += K;
      slot("R4", (s % 5) != 0, v, t, d, (s % 4) != 1);
    end
    repeat (12) slot("R4 drain", 1, 4'b0000, '0, '0, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule